// File: doc/BRIEF.md
# PCM Word Serializer with Differential Encoder

This block turns one 8-bit two's-complement PCM code word per frame into a serial bit stream and encodes that stream in relative form. A 3-bit bit-index counter steps an 8-to-1 multiplexer across the stored word, least significant bit first. The counter advances once per bit period, as marked by a bit-rate tick. With an 8 kHz frame and a 15.625 µs bit period the line rate is 64 kbit/s, which is eight bits per frame.

Each selected data bit is XORed with the encoded bit that went out one bit period earlier, giving the differential code. The encoded bit is also given as a bipolar sign flag, where 1 stands for +1 and 0 stands for −1. A one-cycle frame-start marker flags the clock cycle in which bit 0 of a newly taken word first appears.

Words arrive on a valid strobe at any point in a frame. They are held as pending and taken over only when the counter wraps from 7 back to 0. If no word came during the frame, the last word is sent again.

The controller has two states:
- **ST_IDLE**: the state after reset. No word has been taken yet.
- **ST_SEND**: the state in which a word is being sent.

There are two transitions:
- **ST_IDLE → ST_SEND**: taken on the first word-valid strobe.
- **ST_SEND → ST_SEND**: a self-loop that is taken at every wrap and at every other bit tick.

Only reset returns the controller to ST_IDLE.

Top module: `pcm_diff_serializer`

## Requirements
- R1: In the cycle after a synchronous reset, and while in ST_IDLE, ser_bit, enc_bit, sign_pos and frame_start are all 0.
- R2: A word_vld strobe in ST_IDLE loads word_in at once. In the next cycle, frame_start is 1 and ser_bit shows bit 0 of that word.
- R3: In ST_SEND, each bit_tick advances the bit index by one. ser_bit is word[index], with index 0 (the LSB) sent first and index 7 sent last.
- R4: enc_bit equals ser_bit XOR the enc_bit value that held just before the most recent bit_tick. After reset that stored value is 0, so the first encoded bit equals the first data bit.
- R5: sign_pos equals enc_bit at all times. A value of 1 stands for +1 and a value of 0 stands for −1.
- R6: A bit_tick while the index is 7 wraps the index to 0 and takes the next word. frame_start is 1 for exactly the one following cycle. A word_vld in that same cycle is the word taken.
- R7: If no word_vld arrived since the previous wrap, the wrap re-sends the same word.
- R8: A word_vld in the middle of a frame does not change the bits of the word being sent. If several strobes arrive in one frame, only the last one is used at the wrap.
- R9: bit_tick pulses in ST_IDLE are ignored. The outputs stay 0 and the first word still starts at bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| word_vld | input | 1 | Strobe: word_in holds a new PCM word |
| word_in | input | 8 | PCM code word, two's complement |
| bit_tick | input | 1 | One-cycle pulse that ends each bit period |
| ser_bit | output | 1 | Raw serial data bit |
| enc_bit | output | 1 | Differentially encoded bit |
| sign_pos | output | 1 | Bipolar sign of the line symbol: 1 is +1, 0 is −1 |
| frame_start | output | 1 | One-cycle marker: bit 0 of a newly taken word is now shown |

## Verification
The words 0xA5, 0x00, 0xFF and 0x80 cover alternating bits, long runs of zeros, long runs of ones and a lone sign bit. Together they show whether the encoder toggles correctly on ones and holds correctly on zeros. A strobe in the middle of a frame, a double strobe, a frame with no strobe and a strobe in the wrap cycle separate the four ways a word can be taken. These are the pending word, overwrite of the pending word, repeat of the old word, and direct capture at the wrap. Ticks sent before the first word, and uneven gaps between ticks, show that only bit_tick moves the index.

// File: rtl/pcm_ser_pkg.sv
package pcm_ser_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } ser_state_t;
endpackage

// File: rtl/bit_index_counter.sv
module bit_index_counter #(
    parameter int WORD_W = 8,
    localparam int IDX_W = $clog2(WORD_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             advance,
    output logic [IDX_W-1:0] idx,
    output logic             at_last
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_W - 1);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            idx <= '0;
        end else if (advance) begin
            idx <= (idx == LAST_IDX) ? '0 : idx + 1'b1;
        end
    end

    assign at_last = (idx == LAST_IDX);

    AST_IDX_STEP: assert property (@(posedge clk) disable iff (rst)
        (advance && !clear && idx != LAST_IDX) |=> idx == $past(idx) + 1'b1); // R3
    AST_IDX_WRAP: assert property (@(posedge clk) disable iff (rst)
        (advance && !clear && idx == LAST_IDX) |=> idx == '0); // R6
    AST_IDX_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!advance && !clear) |=> $stable(idx)); // R9
endmodule

// File: rtl/word_holder.sv
module word_holder #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_now,
    input  logic              wrap,
    input  logic              word_vld,
    input  logic [WORD_W-1:0] word_in,
    output logic [WORD_W-1:0] cur_word
);
    logic [WORD_W-1:0] pend_word;
    logic              pend_full;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_word  <= '0;
            pend_word <= '0;
            pend_full <= 1'b0;
        end else if (load_now) begin
            cur_word  <= word_in;
            pend_full <= 1'b0;
        end else if (wrap) begin
            if (word_vld) begin
                cur_word <= word_in;
            end else if (pend_full) begin
                cur_word <= pend_word;
            end
            pend_full <= 1'b0;
        end else if (word_vld) begin
            pend_word <= word_in;
            pend_full <= 1'b1;
        end
    end

    AST_KEEP_MIDFRAME: assert property (@(posedge clk) disable iff (rst)
        (!load_now && !wrap) |=> $stable(cur_word)); // R8
    AST_REPEAT_WORD: assert property (@(posedge clk) disable iff (rst)
        (wrap && !word_vld && !pend_full) |=> $stable(cur_word)); // R7
    AST_WRAP_DIRECT: assert property (@(posedge clk) disable iff (rst)
        (wrap && word_vld) |=> cur_word == $past(word_in)); // R6
endmodule

// File: rtl/diff_encoder.sv
module diff_encoder (
    input  logic clk,
    input  logic rst,
    input  logic step,
    input  logic data,
    output logic enc
);
    logic prev_enc;

    assign enc = data ^ prev_enc;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_enc <= 1'b0;
        end else if (step) begin
            prev_enc <= enc;
        end
    end

    AST_PREV_TRACK: assert property (@(posedge clk) disable iff (rst)
        step |=> prev_enc == $past(enc)); // R4
    AST_PREV_HOLD: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(prev_enc)); // R4
endmodule

// File: rtl/pcm_diff_serializer.sv
module pcm_diff_serializer
    import pcm_ser_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              word_vld,
    input  logic [WORD_W-1:0] word_in,
    input  logic              bit_tick,
    output logic              ser_bit,
    output logic              enc_bit,
    output logic              sign_pos,
    output logic              frame_start
);
    localparam int IDX_W = $clog2(WORD_W);

    ser_state_t        state, state_nx;
    logic [IDX_W-1:0]  idx;
    logic              at_last;
    logic [WORD_W-1:0] cur_word;
    logic              load_now, advance, wrap;

    always_comb begin
        state_nx = state;
        load_now = 1'b0;
        advance  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (word_vld) begin
                    load_now = 1'b1;
                    state_nx = ST_SEND;
                end
            end
            ST_SEND: begin
                advance = bit_tick;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    assign wrap = advance && at_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_start <= 1'b0;
        end else begin
            frame_start <= load_now || wrap;
        end
    end

    bit_index_counter #(.WORD_W(WORD_W)) u_cnt (
        .clk(clk), .rst(rst), .clear(load_now), .advance(advance),
        .idx(idx), .at_last(at_last)
    );

    word_holder #(.WORD_W(WORD_W)) u_hold (
        .clk(clk), .rst(rst), .load_now(load_now), .wrap(wrap),
        .word_vld(word_vld), .word_in(word_in), .cur_word(cur_word)
    );

    assign ser_bit = (state == ST_SEND) ? cur_word[idx] : 1'b0;

    diff_encoder u_enc (
        .clk(clk), .rst(rst), .step(advance), .data(ser_bit), .enc(enc_bit)
    );

    assign sign_pos = enc_bit;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> (!ser_bit && !enc_bit && !frame_start)); // R1
    AST_FS_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> !frame_start); // R6
    AST_FS_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> (idx == '0 && state == ST_SEND)); // R2
endmodule

// File: tb/pcm_diff_serializer_bench.sv
module pcm_diff_serializer_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       word_vld = 1'b0;
    logic [7:0] word_in = '0;
    logic       bit_tick = 1'b0;
    logic       ser_bit, enc_bit, sign_pos, frame_start;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;
    string phase = "R1";

    bit         m_idle = 1;
    logic [7:0] m_word = '0;
    int         m_idx  = 0;
    bit         m_prev = 0;
    bit         m_fs   = 0;
    logic [7:0] m_pend[$];

    always #2 clk = ~clk;

    pcm_diff_serializer u_pcm_diff_serializer (
        .clk(clk), .rst(rst), .word_vld(word_vld), .word_in(word_in),
        .bit_tick(bit_tick), .ser_bit(ser_bit), .enc_bit(enc_bit),
        .sign_pos(sign_pos), .frame_start(frame_start)
    );

    function automatic bit exp_ser();
        return m_idle ? 1'b0 : m_word[m_idx];
    endfunction

    task automatic check1(input string tag, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic model_step(input bit r, input bit v, input logic [7:0] w, input bit t);
        bit e;
        e = exp_ser() ^ m_prev;
        m_fs = 0;
        if (r) begin
            m_idle = 1; m_idx = 0; m_prev = 0; m_word = '0;
            m_pend.delete();
        end else if (m_idle) begin
            if (v) begin
                m_idle = 0; m_word = w; m_idx = 0; m_fs = 1;
            end
        end else if (t) begin
            m_prev = e;
            if (m_idx == 7) begin
                m_idx = 0; m_fs = 1;
                if (v) m_word = w;
                else if (m_pend.size() > 0) m_word = m_pend[$];
                m_pend.delete();
            end else begin
                m_idx++;
                if (v) begin m_pend.delete(); m_pend.push_back(w); end
            end
        end else if (v) begin
            m_pend.delete(); m_pend.push_back(w);
        end
    endtask

    task automatic cyc(input bit r, input bit v, input logic [7:0] w, input bit t);
        bit es;
        @(negedge clk);
        rst = r; word_vld = v; word_in = w; bit_tick = t;
        @(posedge clk);
        model_step(r, v, w, t);
        #1;
        es = exp_ser();
        check1(phase, "ser_bit R3", ser_bit, es);
        check1(phase, "enc_bit R4", enc_bit, es ^ m_prev);
        check1(phase, "sign_pos R5", sign_pos, es ^ m_prev);
        check1(phase, "frame_start R6", frame_start, m_fs);
    endtask

    task automatic ticks(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            for (int g = 1; g < gap; g++) cyc(0, 0, 8'h00, 0);
            cyc(0, 0, 8'h00, 1);
        end
    endtask

    initial begin
        #400000;
        if (!finished) begin
            finished = 1;
            n_fail++; n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        phase = "R1";
        cyc(1, 0, 8'h00, 0);
        cyc(1, 0, 8'h00, 0);
        cyc(0, 0, 8'h00, 0);
        phase = "R9";
        ticks(5, 2);
        cyc(0, 0, 8'h00, 1);
        phase = "R2";
        cyc(0, 1, 8'hA5, 0);
        cyc(0, 0, 8'h00, 0);
        phase = "R3";
        ticks(7, 3);
        phase = "R8";
        cyc(0, 1, 8'h3C, 0);
        ticks(1, 2);
        phase = "R6";
        ticks(4, 2);
        phase = "R8";
        cyc(0, 1, 8'h11, 0);
        ticks(2, 4);
        cyc(0, 1, 8'h00, 0);
        ticks(2, 1);
        phase = "R7";
        ticks(8, 2);
        ticks(8, 3);
        phase = "R6";
        ticks(7, 2);
        cyc(0, 1, 8'hFF, 1);
        ticks(7, 2);
        cyc(0, 1, 8'h80, 1);
        phase = "R4";
        ticks(16, 1);
        cyc(0, 1, 8'h5A, 0);
        ticks(8, 5);
        phase = "R1";
        cyc(1, 0, 8'h00, 1);
        cyc(0, 0, 8'h00, 1);
        phase = "R2";
        cyc(0, 1, 8'h01, 1);
        ticks(10, 2);
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule